// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and a byte-wide asynchronous static RAM with 32768 locations (15 address bits, 8 data bits). The host presents one request at a time through a valid/ready handshake: an address, a write byte and a read/write flag. The controller then drives the memory's active-low chip select, write enable and output enable, holds the address, and handles the bidirectional data path as separate out, in and drive-enable signals, which a pad ring or the bench joins.

Every analog timing window of the memory becomes a whole number of clock cycles. Each count is the nanosecond value divided by the clock period, rounded up, and never less than one. The read strobe lasts as long as the longer of the access time and the read cycle time. The write sequence has a setup phase, a write-enable pulse and a recovery phase. Recovery is stretched when needed so that the whole write meets the write cycle time. Output enable stays high for the whole of every write, so the memory never drives the bus while the controller does, and the minimum write pulse alone is enough. Read data is sampled on the clock edge that ends the access count and returned with a one-cycle valid pulse.

Top module: `async_sram_ctrl`

## Requirements
- R1: After synchronous reset, chip select, write enable and output enable are high, the data driver is off, ready is high and read-valid is low.
- R2: A read holds chip select and output enable low and write enable high for exactly RD_CYC = max(ceil(tAA/T), ceil(tRC/T)) cycles (5 with the defaults). The data input is sampled at the edge that ends that window, and read-valid is high for one cycle right after it, with the sampled byte on rd_data.
- R3: A write holds chip select low for SU_CYC setup cycles with write enable high, then write enable low for exactly WP_CYC = ceil(tWP/T) cycles (4 with the defaults), then HD_CYC = max(ceil(tWR/T), WC_CYC - SU_CYC - WP_CYC) recovery cycles with write enable high. Output enable stays high throughout.
- R4: The data driver is on during every cycle in which write enable is low, stays on through the recovery cycles, and is never on while output enable is low. While it is on, dq_out carries the accepted write byte.
- R5: Write enable is never low while chip select is high.
- R6: The memory address never changes between two consecutive cycles in which both chip select and write enable are low.
- R7: Ready is low from the cycle after a request is accepted until the access ends: RD_CYC cycles for a read, SU_CYC + WP_CYC + HD_CYC cycles for a write, plus one for turnaround. Requests presented while ready is low have no effect.
- R8: When a write is accepted after a read, one extra cycle with every strobe high and the driver off comes before the write setup, so chip select is high for at least two cycles between them.
- R9: Between two accesses chip select is high for at least one cycle.
- R10: Each timing count equals ceil(ns / clock period) with a minimum of one, so zero-nanosecond setup and recovery windows still take one cycle.

Timing parameters are given in nanoseconds together with the clock period T; the cycle counts are derived from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | 8 | Returned read byte |
| sram_cs_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | 15 | Memory address |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_in | input | 8 | Data from the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |

## Verification
A wrong sequencer state shows up at the memory pins within one cycle: a strobe held too long or too short, a driver left on under a low output enable, or an address moving inside a write pulse. The behavioural memory model catches each of these at the cycle it happens. A wrong cycle count shows up as a write pulse of the wrong length when write enable rises, or as an early data capture. The model returns a poison byte until the full access window has passed, so an early capture makes the read-back differ from the expected byte in the valid-pulse cycle. A lost turnaround or a request wrongly accepted while busy surfaces as a short chip-select gap or as corrupted memory contents on the next read of that address.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int DEF_ADDR_W = 15;
    localparam int DEF_DATA_W = 8;

    function automatic int ns2cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TURN   = 3'd1,
        ST_WSETUP = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WHOLD  = 3'd4,
        ST_RACC   = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } strobe_t;

    localparam strobe_t STB_QUIET = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

    function automatic strobe_t strobe_of(input seq_state_t s);
        strobe_t r;
        r = STB_QUIET;
        case (s)
            ST_WSETUP: r = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
            ST_WPULSE: r = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: 1'b1};
            ST_WHOLD:  r = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
            ST_RACC:   r = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drv: 1'b0};
            default:   r = STB_QUIET;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W  = 3,
    parameter int RD_CYC = 5,
    parameter int SU_CYC = 1,
    parameter int WP_CYC = 4,
    parameter int HD_CYC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_fire,
    input  logic             req_write,
    input  logic             t_done,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val,
    output logic             ready,
    output logic             cap_en,
    output logic             cs_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             drv
);
    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] SU_LD = CNT_W'(SU_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] HD_LD = CNT_W'(HD_CYC - 1);

    seq_state_t state_q, state_d;
    logic       last_rd_q;
    strobe_t    stb_q;

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        cap_en  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_fire) begin
                    if (!req_write) begin
                        state_d = ST_RACC;
                        t_load  = 1'b1;
                        t_val   = RD_LD;
                    end else if (last_rd_q) begin
                        state_d = ST_TURN;
                    end else begin
                        state_d = ST_WSETUP;
                        t_load  = 1'b1;
                        t_val   = SU_LD;
                    end
                end
            end
            ST_TURN: begin
                state_d = ST_WSETUP;
                t_load  = 1'b1;
                t_val   = SU_LD;
            end
            ST_WSETUP: begin
                if (t_done) begin
                    state_d = ST_WPULSE;
                    t_load  = 1'b1;
                    t_val   = WP_LD;
                end
            end
            ST_WPULSE: begin
                if (t_done) begin
                    state_d = ST_WHOLD;
                    t_load  = 1'b1;
                    t_val   = HD_LD;
                end
            end
            ST_WHOLD: begin
                if (t_done) state_d = ST_IDLE;
            end
            ST_RACC: begin
                if (t_done) begin
                    state_d = ST_IDLE;
                    cap_en  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            last_rd_q <= 1'b0;
            stb_q     <= STB_QUIET;
        end else begin
            state_q <= state_d;
            stb_q   <= strobe_of(state_d);
            if (req_fire) last_rd_q <= !req_write;
        end
    end

    assign ready = (state_q == ST_IDLE);
    assign cs_n  = stb_q.cs_n;
    assign we_n  = stb_q.we_n;
    assign oe_n  = stb_q.oe_n;
    assign drv   = stb_q.drv;
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cap_en;
            if (cap_en) rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = DEF_ADDR_W,
    parameter int DATA_W        = DEF_DATA_W,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_RC_NS       = 20,
    parameter int T_AA_NS       = 20,
    parameter int T_WC_NS       = 20,
    parameter int T_WP_NS       = 15,
    parameter int T_AS_NS       = 0,
    parameter int T_WR_NS       = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe
);
    localparam int RD_CYC = imax(ns2cyc(T_AA_NS, CLK_PERIOD_NS), ns2cyc(T_RC_NS, CLK_PERIOD_NS));
    localparam int SU_CYC = ns2cyc(T_AS_NS, CLK_PERIOD_NS);
    localparam int WP_CYC = ns2cyc(T_WP_NS, CLK_PERIOD_NS);
    localparam int HD_CYC = imax(ns2cyc(T_WR_NS, CLK_PERIOD_NS),
                                 ns2cyc(T_WC_NS, CLK_PERIOD_NS) - SU_CYC - WP_CYC);
    localparam int MAX_CYC = imax(imax(RD_CYC, SU_CYC), imax(WP_CYC, HD_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             fire;
    logic             t_load, t_done, cap_en;
    logic [CNT_W-1:0] t_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign fire = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (fire) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;

    sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sram_seq_fsm #(
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .SU_CYC (SU_CYC),
        .WP_CYC (WP_CYC),
        .HD_CYC (HD_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (fire),
        .req_write (req_write),
        .t_done    (t_done),
        .t_load    (t_load),
        .t_val     (t_val),
        .ready     (req_ready),
        .cap_en    (cap_en),
        .cs_n      (sram_cs_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n),
        .drv       (sram_dq_oe)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .dq_in    (sram_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              sram_cs_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_dq_oe
);
    // R5
    we_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_cs_n);

    // R4
    drv_vs_oe_chk: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> sram_oe_n);

    // R3
    write_oe_high_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (sram_oe_n && sram_dq_oe));

    // R6
    addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!sram_cs_n && !sram_we_n && $past(!sram_cs_n && !sram_we_n)) |-> $stable(sram_addr));

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    rd_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R8
    no_drive_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!sram_cs_n && !sram_oe_n) |=> !sram_dq_oe);
endmodule

bind async_sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .sram_cs_n  (sram_cs_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_addr  (sram_addr),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sim_async_sram_ctrl.sv
`timescale 1ns/1ps
module sim_async_sram_ctrl;
    localparam int PER  = 4;
    // R10: counts derived here from nanoseconds, ceil and min 1
    localparam int RD   = ((20 + PER - 1) / PER);          // max(tAA, tRC) = 20 ns -> 5
    localparam int SU   = 1;                               // 0 ns -> 1
    localparam int WP   = ((15 + PER - 1) / PER);          // 15 ns -> 4
    localparam int WC   = ((20 + PER - 1) / PER);          // 5
    localparam int HD   = (WC - SU - WP) < 1 ? 1 : (WC - SU - WP);
    localparam int NA   = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [14:0] sram_addr;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in = 8'hEE;

    int checks = 0, fails = 0;
    int nvalid = 0, nreads = 0;
    bit last_acc_rd = 1'b0;

    always #(PER/2) clk = ~clk;

    async_sram_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_cs_n(sram_cs_n),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_addr(sram_addr),
        .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
    );

    function automatic void chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endfunction

    // behavioural memory with timing checks
    logic [7:0] mem [int];
    function automatic logic [7:0] rd_mem(input logic [14:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    logic p_cs = 1, p_we = 1, p_ract = 0;
    logic [14:0] p_addr = '0;
    logic [7:0] wcap = '0;
    int wlow = 0, rcnt = 0, gap = 99;
    bit mon_last_rd = 0;

    always @(negedge clk) begin
        logic ract;
        if (rst) begin
            p_cs = 1; p_we = 1; p_ract = 0; wlow = 0; rcnt = 0; gap = 99;
            mon_last_rd = 0; sram_dq_in = 8'hEE;
        end else begin
            if (!sram_we_n && sram_cs_n) chk(0, "R5 we low without cs", 1, 0);
            if (sram_dq_oe && !sram_oe_n) chk(0, "R4 driver under oe low", 1, 0);
            if (!sram_cs_n && !sram_we_n) begin
                if (!sram_dq_oe || !sram_oe_n) chk(0, "R3/R4 strobes in pulse", {sram_dq_oe, sram_oe_n}, 3);
                wcap = sram_dq_out;
                wlow++;
            end
            if (!p_we && sram_we_n) begin
                chk(wlow == WP, "R3 write pulse length", wlow, WP);
                chk(sram_dq_oe == 1'b1, "R4 drive past we rise", sram_dq_oe, 1);
                mem[int'(p_addr)] = wcap;
                wlow = 0;
            end
            if (!p_cs && !p_we && !sram_cs_n && !sram_we_n && sram_addr != p_addr)
                chk(0, "R6 address moved in pulse", sram_addr, p_addr);
            if (p_cs && !sram_cs_n) begin
                chk(gap >= 1, "R9 cs gap", gap, 1);
                if (sram_oe_n) begin
                    if (mon_last_rd) chk(gap >= 2, "R8 turnaround gap", gap, 2);
                    mon_last_rd = 0;
                end else mon_last_rd = 1;
                gap = 0;
            end
            if (sram_cs_n) gap++;
            ract = !sram_cs_n && !sram_oe_n && sram_we_n;
            if (ract) rcnt = (p_ract && sram_addr == p_addr) ? rcnt + 1 : 1;
            else begin
                if (p_ract) chk(rcnt == RD, "R2 read strobe length", rcnt, RD);
                rcnt = 0;
            end
            sram_dq_in = (ract && rcnt >= RD) ? rd_mem(sram_addr) : 8'hEE;
            if (rd_valid) nvalid++;
            p_cs = sram_cs_n; p_we = sram_we_n; p_ract = ract; p_addr = sram_addr;
        end
    end

    function automatic logic [14:0] addr_of(input int i);
        if (i == 0) return 15'h0000;
        if (i == 1) return 15'h7FFF;
        return 15'((i * 1367 + 211) % 32768);
    endfunction

    function automatic logic [7:0] dat(input int i, input int p);
        return 8'((i * 37 + p * 101 + 5) ^ (p != 0 ? 8'hA5 : 8'h3C));
    endfunction

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        int k, exp;
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        exp = (last_acc_rd ? 1 : 0) + SU + WP + HD;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        k = 1;
        while (!req_ready) begin @(negedge clk); k++; end
        chk(k == exp + 1, "R7 write busy length", k - 1, exp);
        last_acc_rd = 0;
    endtask

    task automatic do_read(input logic [14:0] a, input logic [7:0] e,
                           input bit noise, input logic [14:0] na);
        int k;
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        k = 1;
        nreads++;
        while (!rd_valid) begin
            if (noise && k < RD) begin
                req_valid = 1; req_write = 1; req_addr = na; req_wdata = ~e;
            end else req_valid = 0;
            @(negedge clk); k++;
        end
        req_valid = 0;
        chk(k == RD + 1, "R2 read latency", k, RD + 1);
        chk(rd_data == e, "R2 read data", rd_data, e);
        chk(req_ready == 1'b1, "R7 ready with rd_valid", req_ready, 1);
        last_acc_rd = 1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(sram_cs_n == 1, "R1 cs_n", sram_cs_n, 1);
        chk(sram_we_n == 1, "R1 we_n", sram_we_n, 1);
        chk(sram_oe_n == 1, "R1 oe_n", sram_oe_n, 1);
        chk(sram_dq_oe == 0, "R1 dq_oe", sram_dq_oe, 0);
        chk(req_ready == 1, "R1 ready", req_ready, 1);
        chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
        // back-to-back writes, then back-to-back reads (R3, R2, R10)
        for (int i = 0; i < NA; i++) do_write(addr_of(i), dat(i, 0));
        for (int i = 0; i < NA; i++) do_read(addr_of(i), dat(i, 0), 0, '0);
        // read then write: turnaround (R8), then read back
        for (int i = 0; i < NA; i++) begin
            do_read(addr_of(i), dat(i, 0), 0, '0);
            do_write(addr_of(i), dat(i, 1));
            do_read(addr_of(i), dat(i, 1), 0, '0);
        end
        // R7: writes presented while busy must not land
        do_read(addr_of(2), dat(2, 1), 1, addr_of(3));
        do_read(addr_of(3), dat(3, 1), 0, '0);
        do_read(addr_of(1), dat(1, 1), 1, addr_of(0));
        do_read(addr_of(0), dat(0, 1), 0, '0);
        repeat (4) @(negedge clk);
        chk(nvalid == nreads, "R7 read-valid pulse count", nvalid, nreads);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * PER);
        checks++; fails++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule